// File: doc/BRIEF.md
# Four-Bank DDR Command Scheduler

This block sits between a memory client and the command pins of a DDR SDRAM with four banks. It accepts one read or write request at a time. Each request carries a bank, a row, a column and an auto-precharge flag. The block turns each request into the shortest legal sequence of row-open, row-close and column commands. It tracks, for every bank, whether a row is open and which row that is.

Each timing limit is a down-counter that must reach zero before the command that depends on it may go out. Some counters are kept per bank: activate-to-column, activate-to-activate, activate-to-close, and column-to-close. Others are kept once for the shared data bus: column spacing, write-to-read and read-to-write. A stall input, which a refresh controller drives, holds back new row opens and column commands. Row closes and all counters keep running during a stall.

The block decides a command combinationally from the request and the counters. It registers that command onto the pins, so a command shows on the pins one cycle after it is chosen. A request is accepted (`req_ready` high) in the cycle its column command is chosen. The requester must hold the request fields steady while `req_valid` is high and the request has not been accepted. The column is placed on the low address bits and must be narrower than bit 10.

Top module: `ddr_cmd_sched`

## Requirements
- R1: While reset is low and on the first cycle after it, the pins show deselect (`cs_n` high) and `req_ready` is low.
- R2: Command encodings with `cs_n` low, given as {`ras_n`,`cas_n`,`we_n`}: row open 011, read 101, write 100, row close 010. `ba` carries the request bank as a 2-bit binary number. When no command is issued, `cs_n` is high.
- R3: A row open carries the row on `addr`. A read or write carries the column on the low bits of `addr`, with bit 10 equal to the auto-precharge flag. A row close has `addr` all zero, so bit 10 is low and only one bank closes.
- R4: A request to an idle bank produces a row open, followed T_RCD cycles later by the column command. A request that hits the open row goes straight to the column command. `req_ready` is high only in the cycle the column command is chosen, and that command appears on the pins one cycle later.
- R5: A request that misses the open row produces a row close, then a row open, then the column command. The close comes no sooner than T_RAS after the bank's last row open. The new row open waits T_RP after the close and T_RC after the previous row open.
- R6: A row close waits at least BL/2 cycles after a read to that bank, and at least 1+BL/2+T_WR cycles after a write to that bank.
- R7: Column commands of the same direction, to open rows in the same bank or in different banks, issue BL/2 cycles apart.
- R8: A read waits 1+BL/2+T_WTR cycles after any write. A write waits T_RTW cycles after any read.
- R9: A column command with auto-precharge closes the bank. The next row open to that bank comes T_RP after the later of two points: the earliest legal close for that bank, and the read or write close gap of R6.
- R10: While `stall` is high, no row open, read or write is chosen and `req_ready` stays low. A row close may still be chosen, and timing counters keep counting.
- R11: The block never issues a burst stop encoding (110 with `cs_n` low) and never opens a row in a bank that already has one open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Holds back row open and column commands (refresh) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Auto-precharge after the access |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Row / column address |

## Verification
The request stream starts with an idle bank and a hit on the open row. Together these separate the row-open path from the direct column path, and they show back-to-back reads spaced by half a burst. Misses that arrive just after a row open make T_RAS and T_RC the binding limits. Alternating reads and writes make the write-to-read and read-to-write gaps the binding limits. Auto-precharge accesses followed by a request to the same bank show whether the close point is derived from a read or from a write. Requests sent while `stall` is held tell a blocked row open apart from a row close that is still allowed through.

// File: rtl/ddr_sched_pkg.sv
// Shared types for the DDR command scheduler.
// Assumes: auto-precharge / all-bank select lives on address bit 10.
package ddr_sched_pkg;
    typedef enum logic [2:0] {
        CMD_DESL,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE
    } cmd_e;

    localparam int AP_BIT = 10;
endpackage

// File: rtl/ddr_bank_timer.sv
// Per-bank state: open flag, open row and three down-counters that gate
// row open, column access and row close for this bank.
// Assumes: at most one of do_act/do_pre/do_rd/do_wr is high per cycle, and
// each is only raised when the matching *_ok output is high.
module ddr_bank_timer #(
    parameter int ROW_W  = 13,
    parameter int CNT_W  = 6,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 6,
    parameter int T_RC   = 10,
    parameter int RD2PRE = 2,
    parameter int WR2PRE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic             do_rd,
    input  logic             do_wr,
    input  logic             ap,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             act_ok,
    output logic             col_ok,
    output logic             pre_ok
);
    logic [CNT_W-1:0] act_cnt, col_cnt, pre_cnt;
    logic [CNT_W-1:0] gap, ap_start, ap_act;

    function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
        return (v == '0) ? v : v - CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] umax(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    // Close gap for the current column command and the derived reopen point.
    always_comb begin
        gap      = do_wr ? CNT_W'(WR2PRE) : CNT_W'(RD2PRE);
        ap_start = umax(pre_cnt, gap);
        ap_act   = ap_start + CNT_W'(T_RP - 1);
    end

    // Bank state and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            open_row <= '0;
            act_cnt  <= '0;
            col_cnt  <= '0;
            pre_cnt  <= '0;
        end else begin
            act_cnt <= dec(act_cnt);
            col_cnt <= dec(col_cnt);
            pre_cnt <= dec(pre_cnt);
            if (do_act) begin
                is_open  <= 1'b1;
                open_row <= act_row;
                act_cnt  <= CNT_W'(T_RC - 1);
                col_cnt  <= CNT_W'(T_RCD - 1);
                pre_cnt  <= CNT_W'(T_RAS - 1);
            end else if (do_pre) begin
                is_open <= 1'b0;
                act_cnt <= umax(dec(act_cnt), CNT_W'(T_RP - 1));
            end else if (do_rd || do_wr) begin
                pre_cnt <= umax(dec(pre_cnt), gap - CNT_W'(1));
                if (ap) begin
                    is_open <= 1'b0;
                    act_cnt <= umax(dec(act_cnt), ap_act);
                end
            end
        end
    end

    assign act_ok = !is_open && (act_cnt == '0);
    assign col_ok = is_open && (col_cnt == '0);
    assign pre_ok = is_open && (pre_cnt == '0);
endmodule

// File: rtl/ddr_bus_turn.sv
// Shared data-bus spacing: column-to-column and read/write turnaround.
// Assumes: do_rd and do_wr are never high together.
module ddr_bus_turn #(
    parameter int CNT_W     = 6,
    parameter int BURST_GAP = 2,
    parameter int RD2WR     = 4,
    parameter int WR2RD     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_rd,
    input  logic do_wr,
    output logic rd_ok,
    output logic wr_ok
);
    logic [CNT_W-1:0] rd_cnt, wr_cnt;

    function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
        return (v == '0) ? v : v - CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] umax(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    // Counters for the next legal read and next legal write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            wr_cnt <= '0;
        end else if (do_rd) begin
            rd_cnt <= umax(dec(rd_cnt), CNT_W'(BURST_GAP - 1));
            wr_cnt <= umax(dec(wr_cnt), CNT_W'(RD2WR - 1));
        end else if (do_wr) begin
            wr_cnt <= umax(dec(wr_cnt), CNT_W'(BURST_GAP - 1));
            rd_cnt <= umax(dec(rd_cnt), CNT_W'(WR2RD - 1));
        end else begin
            rd_cnt <= dec(rd_cnt);
            wr_cnt <= dec(wr_cnt);
        end
    end

    assign rd_ok = (rd_cnt == '0);
    assign wr_ok = (wr_cnt == '0);
endmodule

// File: rtl/ddr_cmd_sched.sv
// Top of the DDR command scheduler. Picks one command per cycle for the
// pending request and registers it onto the command pins.
// Assumes: request fields are stable while req_valid is high and not yet
// accepted; COL_W <= AP_BIT; ROW_W > AP_BIT.
module ddr_cmd_sched #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int BL     = 4,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 6,
    parameter int T_RC   = 10,
    parameter int T_WR   = 2,
    parameter int T_WTR  = 2,
    parameter int T_RTW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_ap,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr
);
    import ddr_sched_pkg::*;

    localparam int NBANK  = 1 << BANK_W;
    localparam int HALF   = BL / 2;
    localparam int WR2RD  = 1 + HALF + T_WTR;
    localparam int WR2PRE = 1 + HALF + T_WR;
    localparam int CNT_W  = $clog2(T_RC + T_RAS + WR2PRE + T_RP + WR2RD + T_RTW + 2) + 1;

    cmd_e             sel;
    logic [NBANK-1:0] bk_open, bk_act_ok, bk_col_ok, bk_pre_ok;
    logic [ROW_W-1:0] bk_row [NBANK];
    logic             rd_ok, wr_ok;
    logic [ROW_W-1:0] col_word;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = (req_bank == BANK_W'(b));
        ddr_bank_timer #(
            .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RP(T_RP),
            .T_RAS(T_RAS), .T_RC(T_RC), .RD2PRE(HALF), .WR2PRE(WR2PRE)
        ) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .do_act  (hit && sel == CMD_ACT),
            .do_pre  (hit && sel == CMD_PRE),
            .do_rd   (hit && sel == CMD_RD),
            .do_wr   (hit && sel == CMD_WR),
            .ap      (req_ap),
            .act_row (req_row),
            .is_open (bk_open[b]),
            .open_row(bk_row[b]),
            .act_ok  (bk_act_ok[b]),
            .col_ok  (bk_col_ok[b]),
            .pre_ok  (bk_pre_ok[b])
        );
    end

    ddr_bus_turn #(
        .CNT_W(CNT_W), .BURST_GAP(HALF), .RD2WR(T_RTW), .WR2RD(WR2RD)
    ) u_turn (
        .clk  (clk),
        .rst_n(rst_n),
        .do_rd(sel == CMD_RD),
        .do_wr(sel == CMD_WR),
        .rd_ok(rd_ok),
        .wr_ok(wr_ok)
    );

    // Choose the next command for the pending request.
    always_comb begin
        sel       = CMD_DESL;
        req_ready = 1'b0;
        if (req_valid) begin
            if (bk_open[req_bank]) begin
                if (bk_row[req_bank] == req_row) begin
                    if (!stall && bk_col_ok[req_bank] && (req_write ? wr_ok : rd_ok)) begin
                        sel       = req_write ? CMD_WR : CMD_RD;
                        req_ready = 1'b1;
                    end
                end else if (bk_pre_ok[req_bank]) begin
                    sel = CMD_PRE;
                end
            end else if (!stall && bk_act_ok[req_bank]) begin
                sel = CMD_ACT;
            end
        end
    end

    // Column address word with the auto-precharge flag on bit AP_BIT.
    always_comb begin
        col_word              = '0;
        col_word[COL_W-1:0]   = req_col;
        col_word[AP_BIT]      = req_ap;
    end

    // Register the chosen command onto the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
            ba   <= '0;
            addr <= '0;
        end else begin
            ba   <= req_bank;
            addr <= '0;
            unique case (sel)
                CMD_ACT: begin
                    {cs_n, ras_n, cas_n, we_n} <= 4'b0011;
                    addr <= req_row;
                end
                CMD_RD: begin
                    {cs_n, ras_n, cas_n, we_n} <= 4'b0101;
                    addr <= col_word;
                end
                CMD_WR: begin
                    {cs_n, ras_n, cas_n, we_n} <= 4'b0100;
                    addr <= col_word;
                end
                CMD_PRE: {cs_n, ras_n, cas_n, we_n} <= 4'b0010;
                default: begin
                    {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
                    ba <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ddr_cmd_sched_chk.sv
// Assertion checker for ddr_cmd_sched, attached by bind below.
// Assumes: pins are sampled on the rising clock edge.
module ddr_cmd_sched_chk #(
    parameter int ADDR_W = 13,
    parameter int BL     = 4,
    parameter int AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr
);
    logic pin_act, pin_rd, pin_wr, pin_pre;
    assign pin_act = !cs_n && !ras_n &&  cas_n &&  we_n;
    assign pin_rd  = !cs_n &&  ras_n && !cas_n &&  we_n;
    assign pin_wr  = !cs_n &&  ras_n && !cas_n && !we_n;
    assign pin_pre = !cs_n && !ras_n &&  cas_n && !we_n;

    a_r11_no_burst_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !(ras_n && cas_n && !we_n));

    a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !(pin_act || pin_rd || pin_wr));

    a_r4_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> req_valid);

    a_r4_ready_to_column: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> (pin_rd || pin_wr));

    a_r3_pre_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pre |-> !addr[AP_BIT]);

    if (BL >= 4) begin : g_gap
        a_r7_column_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_rd || pin_wr) |=> !(pin_rd || pin_wr));
    end
endmodule

bind ddr_cmd_sched ddr_cmd_sched_chk #(
    .ADDR_W(ROW_W), .BL(BL), .AP_BIT(ddr_sched_pkg::AP_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .addr     (addr)
);

// File: tb/tb_ddr_cmd_sched.sv
`timescale 1ns/1ps
// Scoreboard bench: the stimulus pushes expected commands with their
// expected spacing; a monitor pops and compares each command on the pins.
module tb_ddr_cmd_sched;
    localparam int BANK_W = 2, ROW_W = 13, COL_W = 10, BL = 4;
    localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 10;
    localparam int T_WR = 2, T_WTR = 2, T_RTW = 4;
    localparam int HALF = BL / 2;
    localparam int WR2RD = 1 + HALF + T_WTR;
    localparam int WR2PRE = 1 + HALF + T_WR;
    localparam int AP = 1 << 10;
    localparam int K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4, K_BST = 5, K_OTH = 6;

    logic clk = 1'b0, rst_n = 1'b0, stall = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic req_ready, cs_n, ras_n, cas_n, we_n;
    logic [BANK_W-1:0] ba;
    logic [ROW_W-1:0] addr;

    always #2.5 clk = ~clk;

    ddr_cmd_sched #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BL(BL), .T_RCD(T_RCD),
        .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .T_WR(T_WR), .T_WTR(T_WTR), .T_RTW(T_RTW)
    ) dut (.*);

    typedef struct { int kind; int bank; int adr; int delta; string req; } exp_t;
    exp_t q[$];
    int n_chk = 0, n_err = 0, cyc = 0, last_cyc = -1;
    logic st_q = 1'b0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic expect_cmd(input int k, input int b, input int a, input int d, input string r);
        exp_t e;
        e.kind = k; e.bank = b; e.adr = a; e.delta = d; e.req = r;
        q.push_back(e);
    endtask

    // Drive one request and hold it until accepted.
    task automatic send(input bit wr, input bit ap, input int b, input int row, input int col);
        bit got;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_ap = ap;
        req_bank = BANK_W'(b); req_row = ROW_W'(row); req_col = COL_W'(col);
        forever begin
            #1 got = req_ready;
            @(posedge clk);
            if (got) break;
            @(negedge clk);
        end
    endtask

    task automatic drop();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Cycle count and stall value seen by each decision cycle.
    always @(posedge clk) begin
        cyc  <= cyc + 1;
        st_q <= stall;
    end

    // Monitor: decode pins away from the edge and compare with the scoreboard.
    always @(negedge clk) begin
        int k;
        exp_t e;
        if (rst_n && !cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011: k = K_ACT;
                3'b101: k = K_RD;
                3'b100: k = K_WR;
                3'b010: k = K_PRE;
                3'b110: k = K_BST;
                default: k = K_OTH;
            endcase
            chk(k != K_BST, "R11", "burst stop on pins", k, 0);
            if (k != K_PRE) chk(!st_q, "R10", "command issued during stall", k, K_PRE);
            if (q.size() == 0) begin
                chk(1'b0, "R4", "unexpected command", k, 0);
            end else begin
                e = q.pop_front();
                chk(k == e.kind, "R2", {"command kind ", e.req}, k, e.kind);
                chk(int'(ba) == e.bank, "R2", {"bank ", e.req}, int'(ba), e.bank);
                chk(int'(addr) == e.adr, "R3", {"address ", e.req}, int'(addr), e.adr);
                if (e.delta >= 0)
                    chk(cyc - last_cyc == e.delta, e.req, "spacing", cyc - last_cyc, e.delta);
            end
            last_cyc = cyc;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
        chk(req_ready == 1'b0, "R1", "ready in reset", int'(req_ready), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1", "cs_n after reset", int'(cs_n), 1);
        chk(req_ready == 1'b0, "R1", "ready after reset", int'(req_ready), 0);

        // Idle bank, then open-row hit back to back (R4, R7).
        expect_cmd(K_ACT, 0, 5, -1, "R4");
        expect_cmd(K_RD, 0, 8, T_RCD, "R4");
        send(0, 0, 0, 5, 8);
        expect_cmd(K_RD, 0, 12, HALF, "R7");
        send(0, 0, 0, 5, 12);
        expect_cmd(K_ACT, 1, 7, 1, "R4");
        expect_cmd(K_RD, 1, 0, T_RCD, "R4");
        send(0, 0, 1, 7, 0);
        // Row miss on bank 0 (R5).
        expect_cmd(K_PRE, 0, 0, 1, "R5");
        expect_cmd(K_ACT, 0, 9, T_RP, "R5");
        expect_cmd(K_WR, 0, 4, T_RCD, "R5");
        send(1, 0, 0, 9, 4);
        // Turnarounds (R8).
        expect_cmd(K_RD, 1, 2, WR2RD, "R8");
        send(0, 0, 1, 7, 2);
        expect_cmd(K_WR, 0, 6 | AP, T_RTW, "R8");
        send(1, 1, 0, 9, 6);
        // Reopen after write auto-precharge (R9).
        expect_cmd(K_ACT, 0, 9, WR2PRE + T_RP, "R9");
        expect_cmd(K_RD, 0, 0, T_RCD, "R4");
        send(0, 0, 0, 9, 0);
        expect_cmd(K_RD, 1, 4 | AP, HALF, "R7");
        send(0, 1, 1, 7, 4);
        // Reopen after read auto-precharge (R9).
        expect_cmd(K_ACT, 1, 3, HALF + T_RP, "R9");
        expect_cmd(K_WR, 1, 1, T_RCD, "R4");
        send(1, 0, 1, 3, 1);
        // Write-to-close gap (R6).
        expect_cmd(K_PRE, 1, 0, WR2PRE, "R6");
        expect_cmd(K_ACT, 1, 4, T_RP, "R5");
        expect_cmd(K_RD, 1, 0, T_RCD, "R4");
        send(0, 0, 1, 4, 0);
        // tRAS then tRC binding (R5).
        expect_cmd(K_PRE, 1, 0, T_RAS - T_RCD, "R5");
        expect_cmd(K_ACT, 1, 5, T_RC - T_RAS, "R5");
        expect_cmd(K_RD, 1, 0, T_RCD, "R4");
        send(0, 0, 1, 5, 0);
        // Stall holds back the row open (R10).
        expect_cmd(K_ACT, 2, 1, -1, "R10");
        expect_cmd(K_RD, 2, 0, T_RCD, "R10");
        fork
            send(0, 0, 2, 1, 0);
            begin @(negedge clk); stall = 1'b1; repeat (6) @(negedge clk); stall = 1'b0; end
        join
        // Stall lets the row close through (R10).
        expect_cmd(K_PRE, 2, 0, T_RAS - T_RCD, "R10");
        expect_cmd(K_ACT, 2, 2, -1, "R10");
        expect_cmd(K_RD, 2, 0, T_RCD, "R10");
        fork
            send(0, 0, 2, 2, 0);
            begin @(negedge clk); stall = 1'b1; repeat (10) @(negedge clk); stall = 1'b0; end
        join
        drop();
        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R4", "expected commands left over", q.size(), 0);
        chk(cs_n == 1'b1, "R2", "deselect when idle", int'(cs_n), 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R4", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule